// File: doc/BRIEF.md
# Bus Coupling-Aware Switching Energy Monitor

This block observes a parallel on-chip bus and estimates how much capacitance the bus drivers charge from the supply on each sampled transition. It keeps the last sampled word and compares it with each new sampled word. For every wire that rises, it works out the effective neighbour-coupling load. A neighbour that rises with the victim adds no load. A neighbour that falls against it adds two units. A neighbour that holds still adds one unit. Falling and steady wires draw nothing from the supply and so contribute nothing.

The per-cycle coupling weight is published in units of the neighbour-to-neighbour capacitance. Two saturating totals accumulate over time. One holds the coupling weight. The other adds one for each rising wire, which accounts for that wire's own capacitance to ground. A clear pulse restarts the measurement window. Converting the counts to energy is left to whatever reads the totals.

Top module: `bus_cpl_energy_mon`

## Requirements
- R1: Only a wire that goes from 0 to 1 between two compared samples (a rising victim) adds coupling weight; a wire that falls or stays unchanged adds 0.
- R2: For a rising victim, a neighbour that also rises adds 0 units.
- R3: For a rising victim, a neighbour that falls adds 2 units, so two falling neighbours give 4.
- R4: For a rising victim, a neighbour that keeps its value adds 1 unit, so two steady neighbours give 2.
- R5: Bit i of `bus_i` is adjacent to bits i-1 and i+1. Bit 0 and bit BUS_W-1 have only one neighbour, and the missing side adds nothing.
- R6: `coup_weight_o` is registered. It shows the weight of the comparison made at a clock edge from that edge onward, and it is 0 after any edge where no comparison took place.
- R7: A cycle with `smp_vld_i` low is ignored. The stored word is kept, and the totals and weight do not change from it.
- R8: The first valid sample after reset or after a clear is only stored. It adds nothing to either total and gives a weight of 0.
- R9: `self_total_o` grows by the number of rising wires in each comparison.
- R10: Both totals saturate at their all-ones value and stay there until cleared.
- R11: `clr_i` zeroes both totals at the next edge and takes priority over accumulation. A sample presented in the same cycle as `clr_i` is discarded, so the next valid sample is treated as a first sample.
- R12: After reset, both totals and the weight read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Marks the bus word of this cycle as a sample |
| bus_i | input | BUS_W | Observed bus word |
| clr_i | input | 1 | Zeroes both totals and restarts the window |
| coup_weight_o | output | $clog2(4*BUS_W+1) | Coupling weight of the last comparison, in neighbour-capacitance units |
| coup_total_o | output | ACC_W | Saturating total of coupling weight |
| self_total_o | output | ACC_W | Saturating total of rising-wire events |

## Verification
Two pairs of events can land in the same cycle. In the first, a clear pulse coincides with a valid sample whose transition would otherwise add weight. The bench drives both together. It then expects both totals at zero, and it expects the following sample to be treated as a first sample, which shows that the coinciding word was discarded. In the second, saturation of the coupling total coincides with continued counting of rising wires. An alternating pattern drives the coupling total past its ceiling while the self total is still far below its own. The bench checks that the coupling total is pinned at all ones while the self total keeps its exact expected count.

// File: rtl/cpl_pkg.sv
package cpl_pkg;

    typedef enum logic [1:0] {
        TR_STEADY = 2'd0,
        TR_RISE   = 2'd1,
        TR_FALL   = 2'd2
    } trans_e;

    typedef struct packed {
        logic       rise;
        logic [2:0] cost;
    } wire_cost_t;

    function automatic trans_e classify(input logic old_b, input logic new_b);
        if (!old_b && new_b)
            return TR_RISE;
        else if (old_b && !new_b)
            return TR_FALL;
        else
            return TR_STEADY;
    endfunction

    // Load one neighbour puts on a victim wire, in coupling units.
    function automatic logic [2:0] pair_cost(input trans_e victim, input trans_e nb);
        logic [2:0] c;
        if (victim != TR_RISE)
            c = 3'd0;
        else begin
            case (nb)
                TR_RISE: c = 3'd0;
                TR_FALL: c = 3'd2;
                default: c = 3'd1;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/cpl_wire_cost.sv
module cpl_wire_cost
    import cpl_pkg::*;
#(
    parameter bit HAS_LO = 1'b1,
    parameter bit HAS_HI = 1'b1
) (
    input  logic [2:0]  old_i,
    input  logic [2:0]  new_i,
    output wire_cost_t  cost_o
);
    // Index 0: lower neighbour, 1: victim, 2: upper neighbour.
    trans_e     t_lo, t_self, t_hi;
    logic [2:0] c_lo, c_hi;

    always_comb begin
        t_lo   = classify(old_i[0], new_i[0]);
        t_self = classify(old_i[1], new_i[1]);
        t_hi   = classify(old_i[2], new_i[2]);
        c_lo   = HAS_LO ? pair_cost(t_self, t_lo) : 3'd0;
        c_hi   = HAS_HI ? pair_cost(t_self, t_hi) : 3'd0;
        cost_o.rise = (t_self == TR_RISE);
        cost_o.cost = c_lo + c_hi;
    end

    // R1: a victim that is not rising never carries a cost
    always_comb begin
        a_r1_idle_victim_free: assert (cost_o.rise || cost_o.cost == 3'd0)
            else $error("non-rising wire has cost");
    end

endmodule

// File: rtl/cpl_sample_reg.sv
module cpl_sample_reg #(
    parameter int unsigned BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             vld_i,
    input  logic [BUS_W-1:0] word_i,
    output logic [BUS_W-1:0] prev_o,
    output logic             armed_o
);
    logic [BUS_W-1:0] prev_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            prev_q  <= '0;
            armed_q <= 1'b0;
        end else if (vld_i) begin
            prev_q  <= word_i;
            armed_q <= 1'b1;
        end
    end

    assign prev_o  = prev_q;
    assign armed_o = armed_q;

    // R7: stored word holds across invalid cycles
    a_r7_hold_prev: assert property (@(posedge clk) disable iff (rst)
        (!vld_i && !clr_i) |=> $stable(prev_q))
        else $error("stored word moved without a sample");

    // R11: clear disarms the comparison
    a_r11_clear_disarms: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !armed_q)
        else $error("still armed after clear");

endmodule

// File: rtl/cpl_sat_acc.sv
module cpl_sat_acc #(
    parameter int unsigned ACC_W = 32,
    parameter int unsigned INC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [ACC_W-1:0] acc_o
);
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    always_comb begin
        sum = {1'b0, acc_q} + (ACC_W+1)'(inc_i);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            acc_q <= '0;
        else if (en_i)
            acc_q <= sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];
    end

    assign acc_o = acc_q;

    // R10: never wraps downward while not cleared
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (acc_q >= $past(acc_q)))
        else $error("accumulator decreased");

    // R10: once pinned it stays pinned
    a_r10_sat_hold: assert property (@(posedge clk) disable iff (rst)
        (acc_q == ACC_MAX && !clr_i) |=> (acc_q == ACC_MAX))
        else $error("saturated value left ceiling");

endmodule

// File: rtl/bus_cpl_energy_mon.sv
module bus_cpl_energy_mon
    import cpl_pkg::*;
#(
    parameter int unsigned BUS_W = 32,
    parameter int unsigned ACC_W = 32,
    localparam int unsigned WGT_W = $clog2(4*BUS_W+1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld_i,
    input  logic [BUS_W-1:0] bus_i,
    input  logic             clr_i,
    output logic [WGT_W-1:0] coup_weight_o,
    output logic [ACC_W-1:0] coup_total_o,
    output logic [ACC_W-1:0] self_total_o
);
    localparam int unsigned CNT_W   = $clog2(BUS_W+1);
    localparam int unsigned WGT_MAX = (BUS_W > 1) ? 4*BUS_W - 4 : 0;

    logic [BUS_W-1:0] prev_word;
    logic             armed;
    logic [BUS_W+1:0] old_ext, new_ext;
    wire_cost_t       costs [BUS_W];
    logic [WGT_W-1:0] wgt_sum;
    logic [CNT_W-1:0] rise_sum;
    logic             cmp_en;
    logic [WGT_W-1:0] weight_q;

    cpl_sample_reg #(.BUS_W(BUS_W)) u_smp (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (clr_i),
        .vld_i   (smp_vld_i),
        .word_i  (bus_i),
        .prev_o  (prev_word),
        .armed_o (armed)
    );

    assign old_ext = {1'b0, prev_word, 1'b0};
    assign new_ext = {1'b0, bus_i, 1'b0};

    for (genvar i = 0; i < BUS_W; i++) begin : g_wire
        cpl_wire_cost #(
            .HAS_LO (i > 0),
            .HAS_HI (i < BUS_W - 1)
        ) u_cost (
            .old_i  (old_ext[i+2:i]),
            .new_i  (new_ext[i+2:i]),
            .cost_o (costs[i])
        );
    end

    always_comb begin
        wgt_sum  = '0;
        rise_sum = '0;
        for (int k = 0; k < BUS_W; k++) begin
            wgt_sum  = wgt_sum + WGT_W'(costs[k].cost);
            rise_sum = rise_sum + CNT_W'(costs[k].rise);
        end
    end

    assign cmp_en = smp_vld_i && armed && !clr_i;

    always_ff @(posedge clk) begin
        if (rst)
            weight_q <= '0;
        else
            weight_q <= cmp_en ? wgt_sum : '0;
    end

    cpl_sat_acc #(.ACC_W(ACC_W), .INC_W(WGT_W)) u_coup_acc (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr_i),
        .en_i  (cmp_en),
        .inc_i (wgt_sum),
        .acc_o (coup_total_o)
    );

    cpl_sat_acc #(.ACC_W(ACC_W), .INC_W(CNT_W)) u_self_acc (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr_i),
        .en_i  (cmp_en),
        .inc_i (rise_sum),
        .acc_o (self_total_o)
    );

    assign coup_weight_o = weight_q;

    // R11: clear wins over any accumulation
    a_r11_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (coup_total_o == '0 && self_total_o == '0))
        else $error("totals not zero after clear");

    // R8: first sample after reset or clear only loads
    a_r8_first_load_only: assert property (@(posedge clk) disable iff (rst)
        (smp_vld_i && !armed) |=> (coup_weight_o == '0))
        else $error("weight on first sample");

    // R6 / R7: no comparison, no weight
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !smp_vld_i |=> (coup_weight_o == '0))
        else $error("weight without a sample");

    // R5: edge wires cap the per-cycle weight
    a_r5_weight_bound: assert property (@(posedge clk) disable iff (rst)
        coup_weight_o <= WGT_W'(WGT_MAX))
        else $error("weight above bus worst case");

endmodule

// File: tb/tb_bus_cpl_energy_mon.sv
module tb_bus_cpl_energy_mon;

    localparam int unsigned BW  = 8;
    localparam int unsigned AW  = 12;
    localparam int unsigned WW  = $clog2(4*BW+1);
    localparam int unsigned NV  = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          vld = 1'b0;
    logic [BW-1:0] bus = '0;
    logic          clr = 1'b0;
    logic [WW-1:0] weight;
    logic [AW-1:0] ctot, stot;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    int exp_c = 0;
    int exp_s = 0;

    always #2 clk = ~clk;   // 250 MHz

    bus_cpl_energy_mon #(.BUS_W(BW), .ACC_W(AW)) dut (
        .clk           (clk),
        .rst           (rst),
        .smp_vld_i     (vld),
        .bus_i         (bus),
        .clr_i         (clr),
        .coup_weight_o (weight),
        .coup_total_o  (ctot),
        .self_total_o  (stot)
    );

    // {valid, word, expected weight, expected rising wires}
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 8'h00, 6'd0,  4'd0},  // R8 first sample loads
        {1'b1, 8'h01, 6'd1,  4'd1},  // R5 edge wire, one steady neighbour
        {1'b1, 8'h03, 6'd2,  4'd1},  // R4 two steady neighbours
        {1'b1, 8'h00, 6'd0,  4'd0},  // R1 falls only
        {1'b1, 8'hFF, 6'd0,  4'd8},  // R2 all rise together, R9
        {1'b1, 8'h00, 6'd0,  4'd0},  // R1
        {1'b1, 8'h55, 6'd7,  4'd4},  // R4 R5 steady neighbours
        {1'b1, 8'hAA, 6'd14, 4'd4},  // R3 opposing neighbours
        {1'b0, 8'hFF, 6'd0,  4'd0},  // R7 ignored
        {1'b1, 8'h55, 6'd14, 4'd4},  // R7 compares with AA
        {1'b1, 8'h5D, 6'd2,  4'd1},  // R4
        {1'b1, 8'h80, 6'd2,  4'd1},  // R3 R5 top edge
        {1'b1, 8'h81, 6'd1,  4'd1},  // R5 bottom edge
        {1'b1, 8'h06, 6'd3,  4'd2}   // R2 R3 R4 mixed
    };

    task automatic chk(input string req, input int got, input int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step(input logic v, input logic [BW-1:0] w, input logic c);
        @(negedge clk);
        vld = v;
        bus = w;
        clr = c;
        @(negedge clk);
        vld = 1'b0;
        clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 weight", int'(weight), 0);
        chk("R12 coup total", int'(ctot), 0);
        chk("R12 self total", int'(stot), 0);

        // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][18], VEC[i][17:10], 1'b0);
            exp_c += int'(VEC[i][9:4]);
            exp_s += int'(VEC[i][3:0]);
            chk($sformatf("R1/R6 weight row %0d", i), int'(weight), int'(VEC[i][9:4]));
            chk($sformatf("R9 self total row %0d", i), int'(stot), exp_s);
            chk($sformatf("R3 coup total row %0d", i), int'(ctot), exp_c);
        end
        @(negedge clk);
        chk("R6 weight idle", int'(weight), 0);

        // R11 clear alone
        step(1'b0, 8'h00, 1'b1);
        chk("R11 coup cleared", int'(ctot), 0);
        chk("R11 self cleared", int'(stot), 0);
        step(1'b1, 8'h00, 1'b0);
        chk("R8 after clear weight", int'(weight), 0);
        chk("R8 after clear total", int'(ctot), 0);
        step(1'b1, 8'hFF, 1'b0);
        chk("R9 all rising", int'(stot), 8);
        chk("R2 all rising weight", int'(weight), 0);

        // R11 clear with a weighty sample in the same cycle
        step(1'b1, 8'h00, 1'b0);
        step(1'b1, 8'h01, 1'b1);
        chk("R11 priority coup", int'(ctot), 0);
        chk("R11 priority self", int'(stot), 0);
        chk("R11 priority weight", int'(weight), 0);
        step(1'b1, 8'h03, 1'b0);
        chk("R11 discarded sample weight", int'(weight), 0);
        chk("R11 discarded sample total", int'(ctot), 0);
        step(1'b1, 8'h07, 1'b0);
        chk("R4 after rearm weight", int'(weight), 2);
        chk("R4 after rearm total", int'(ctot), 2);
        chk("R9 after rearm self", int'(stot), 1);

        // R12 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R12 coup after reset", int'(ctot), 0);
        chk("R12 self after reset", int'(stot), 0);
        step(1'b1, 8'h0F, 1'b0);
        chk("R8 after reset weight", int'(weight), 0);
        chk("R8 after reset self", int'(stot), 0);

        // R10 saturation of the coupling total
        step(1'b0, 8'h00, 1'b1);
        for (int n = 0; n < 300; n++)
            step(1'b1, (n % 2 == 0) ? 8'h55 : 8'hAA, 1'b0);
        chk("R10 coup saturated", int'(ctot), 4095);
        chk("R10 self unsaturated", int'(stot), 4*299);
        chk("R3 weight while saturated", int'(weight), 14);
        step(1'b1, 8'h55, 1'b0);
        chk("R10 coup stays saturated", int'(ctot), 4095);
        chk("R9 self keeps counting", int'(stot), 4*300);

        finish_run();
    end

endmodule